// File: doc/BRIEF.md
# Segmented Page-Table Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address in two steps. The top bits of the address pick a segment from a small register table. Each segment entry holds the memory address of that segment's page table and the highest page index the table covers. When the page index is within range, the block reads one page-table word from memory. It then joins the physical page number from that word to the untouched byte offset.

Software fills the segment table through a write port before it issues translations. Translations arrive on a valid/ready request channel, and the block works on one at a time. Each result leaves on a valid/ready response channel with a two-bit fault code. The memory side is a request channel with its own ready and a response strobe that may come after any delay. Segment faults and bound faults are found before any memory traffic, so they never cause a read.

Top module: `spt_xlate_unit`

## Requirements
- R1: The virtual address is split into a segment number in bits 31:29, a page index in bits 28:12 and a byte offset in bits 11:0.
- R2: A write with `seg_wr_en` high sets base, bound and enable for segment indices 0 to 5. A write to index 6 or 7 has no effect, and those indices always fault.
- R3: A segment index of 6 or 7, or a segment whose enable is clear, returns fault code 3 with physical address 0 and issues no memory read. Segment faults take priority over the bound check.
- R4: A page index greater than the segment's bound returns fault code 1 with physical address 0 and issues no memory read. A page index equal to the bound is legal.
- R5: A legal translation issues exactly one memory read, at address = segment base + page index × 4.
- R6: A page-table word carries its valid flag in bit 31 and the physical page number in bits 17:0. When the flag is clear, the result is fault code 2 with physical address 0.
- R7: A valid page-table word yields fault code 0 and physical address {page number, offset}.
- R8: `req_ready` is high only while the unit is idle. It is low from the cycle after a request is accepted until the response is taken.
- R9: The memory request holds `mem_req_valid` and a stable address until `mem_req_ready` is seen. The memory response may come after any number of cycles.
- R10: The response stays valid and unchanged until `rsp_ready` is high.
- R11: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0 and every segment is disabled.
- R12: A segment or bound fault is presented one clock after the request is accepted. Any other result is presented one clock after `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_wr_en | input | 1 | Segment table write strobe |
| seg_wr_idx | input | 3 | Segment index written |
| seg_wr_base | input | 32 | Page-table base address |
| seg_wr_bound | input | 17 | Highest legal page index |
| seg_wr_enable | input | 1 | Segment in use |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken |
| rsp_paddr | output | 30 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 ok, 1 bound, 2 page, 3 segment |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Page-table word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page-table word |

## Verification
The bench counts falling edges after the acceptance edge. For a fault found before memory, the response is due at the second falling edge. For a legal lookup, it is due at stall + latency + 3 falling edges, where the stall comes from delaying `mem_req_ready` and the latency from delaying the response. The bench checks this count for every transaction, along with the number of reads and the read address. It also delays `rsp_ready` on some transactions to confirm the response holds. It sweeps every segment index and every page index up to one past each bound, with varied stalls and latencies. Its expected results come from arithmetic on a model segment table and a computed page-table function.

// File: rtl/spt_pkg.sv
package spt_pkg;
    localparam int VA_W      = 32;
    localparam int SEG_W     = 3;
    localparam int OFF_W     = 12;
    localparam int VPN_W     = VA_W - SEG_W - OFF_W;
    localparam int PPN_W     = 18;
    localparam int PA_W      = PPN_W + OFF_W;
    localparam int NUM_SEG   = 6;
    localparam int MEM_AW    = 32;
    localparam int MEM_DW    = 32;
    localparam int PTE_SHIFT = 2;
    localparam int PTE_VBIT  = MEM_DW - 1;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_BOUND = 2'd1,
        FLT_PAGE  = 2'd2,
        FLT_SEG   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_DONE
    } xl_state_e;

    typedef struct packed {
        logic              en;
        logic [MEM_AW-1:0] base;
        logic [VPN_W-1:0]  bound;
    } seg_entry_t;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [VPN_W-1:0] vpn;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    function automatic logic pte_is_valid(input logic [MEM_DW-1:0] w);
        return w[PTE_VBIT];
    endfunction

    function automatic logic [PPN_W-1:0] pte_ppn(input logic [MEM_DW-1:0] w);
        return w[PPN_W-1:0];
    endfunction

    function automatic logic [MEM_AW-1:0] pte_offset(input logic [VPN_W-1:0] vpn);
        return MEM_AW'({vpn, {PTE_SHIFT{1'b0}}});
    endfunction
endpackage

// File: rtl/spt_segtab.sv
module spt_segtab
    import spt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SEG_W-1:0]   wr_idx,
    input  seg_entry_t         wr_entry,
    input  logic [SEG_W-1:0]   rd_idx,
    output seg_entry_t         rd_entry
);
    seg_entry_t          regs [NUM_SEG];
    logic [NUM_SEG-1:0]  en_vec;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_en && wr_idx == SEG_W'(g)) begin
                regs[g] <= wr_entry;
            end
        end
        assign en_vec[g] = regs[g].en;
    end

    always_comb begin
        rd_entry = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_idx == SEG_W'(i)) rd_entry = regs[i];
        end
    end

    // R2: writes to unused indices leave the table unchanged
    a_r2_unused_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_idx) >= NUM_SEG) |=> $stable(en_vec));

    // R3: an unused index never reads back as enabled
    a_r3_unused_disabled: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_idx) >= NUM_SEG) |-> !rd_entry.en);
endmodule

// File: rtl/spt_check.sv
module spt_check
    import spt_pkg::*;
(
    input  vaddr_t             va,
    input  seg_entry_t         ent,
    output fault_e             fault,
    output logic [MEM_AW-1:0]  pte_addr
);
    always_comb begin
        if (!ent.en)                 fault = FLT_SEG;
        else if (va.vpn > ent.bound) fault = FLT_BOUND;
        else                         fault = FLT_NONE;
    end

    assign pte_addr = ent.base + pte_offset(va.vpn);
endmodule

// File: rtl/spt_fsm.sv
module spt_fsm
    import spt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    output vaddr_t             va_q,
    input  fault_e             chk_fault,
    input  logic [MEM_AW-1:0]  chk_addr,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [MEM_AW-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [MEM_DW-1:0]  mem_rsp_data,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [PA_W-1:0]    rsp_paddr,
    output fault_e             rsp_fault
);
    xl_state_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            va_q      <= '0;
            rsp_paddr <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    va_q <= vaddr_t'(req_vaddr);
                    st   <= ST_FETCH;
                end
                ST_FETCH: if (chk_fault != FLT_NONE) begin
                    rsp_fault <= chk_fault;
                    rsp_paddr <= '0;
                    st        <= ST_DONE;
                end else if (mem_req_ready) begin
                    st <= ST_WAIT;
                end
                ST_WAIT: if (mem_rsp_valid) begin
                    if (pte_is_valid(mem_rsp_data)) begin
                        rsp_fault <= FLT_NONE;
                        rsp_paddr <= {pte_ppn(mem_rsp_data), va_q.off};
                    end else begin
                        rsp_fault <= FLT_PAGE;
                        rsp_paddr <= '0;
                    end
                    st <= ST_DONE;
                end
                ST_DONE: if (rsp_ready) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (st == ST_IDLE);
    assign mem_req_valid = (st == ST_FETCH) && (chk_fault == FLT_NONE);
    assign mem_req_addr  = chk_addr;
    assign rsp_valid     = (st == ST_DONE);

    // R9: request held with a stable address until accepted
    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10: response held until taken
    a_r10_rsp_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

    // R8: idle means nothing else is in flight
    a_r8_ready_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!rsp_valid && !mem_req_valid));

    // R12: early faults come straight from the fetch step
    a_r12_early_fault: assert property (@(posedge clk) disable iff (rst)
        ($rose(rsp_valid) && (rsp_fault == FLT_SEG || rsp_fault == FLT_BOUND))
            |-> $past(st == ST_FETCH));

    // R7: a clean result follows a memory response
    a_r7_ok_after_mem: assert property (@(posedge clk) disable iff (rst)
        ($rose(rsp_valid) && rsp_fault == FLT_NONE) |-> $past(mem_rsp_valid));
endmodule

// File: rtl/spt_xlate_unit.sv
module spt_xlate_unit
    import spt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 seg_wr_en,
    input  logic [SEG_W-1:0]     seg_wr_idx,
    input  logic [MEM_AW-1:0]    seg_wr_base,
    input  logic [VPN_W-1:0]     seg_wr_bound,
    input  logic                 seg_wr_enable,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [VA_W-1:0]      req_vaddr,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [PA_W-1:0]      rsp_paddr,
    output logic [1:0]           rsp_fault,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [MEM_AW-1:0]    mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [MEM_DW-1:0]    mem_rsp_data
);
    seg_entry_t         wr_ent, sel_ent;
    vaddr_t             va_q;
    fault_e             chk_fault, fault_q;
    logic [MEM_AW-1:0]  chk_addr;

    assign wr_ent = '{en: seg_wr_enable, base: seg_wr_base, bound: seg_wr_bound};

    spt_segtab u_tab (
        .clk(clk), .rst(rst),
        .wr_en(seg_wr_en), .wr_idx(seg_wr_idx), .wr_entry(wr_ent),
        .rd_idx(va_q.seg), .rd_entry(sel_ent)
    );

    spt_check u_chk (
        .va(va_q), .ent(sel_ent), .fault(chk_fault), .pte_addr(chk_addr)
    );

    spt_fsm u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .va_q(va_q), .chk_fault(chk_fault), .chk_addr(chk_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(fault_q)
    );

    assign rsp_fault = fault_q;

    // R6: a page fault or any other fault carries a zero address
    a_r6_fault_zero_pa: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));
endmodule

// File: tb/sim_spt_xlate_unit.sv
module sim_spt_xlate_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        seg_wr_en = 0;
    logic [2:0]  seg_wr_idx = 0;
    logic [31:0] seg_wr_base = 0;
    logic [16:0] seg_wr_bound = 0;
    logic        seg_wr_enable = 0;
    logic        req_valid = 0;
    logic        req_ready;
    logic [31:0] req_vaddr = 0;
    logic        rsp_valid;
    logic        rsp_ready = 0;
    logic [29:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = 0;

    int checks = 0;
    int errors = 0;

    logic        m_en   [8];
    logic [31:0] m_base [8];
    logic [16:0] m_bnd  [8];

    always #4 clk = ~clk;

    spt_xlate_unit u0 (.*);

    function automatic logic [31:0] pte_of(input logic [31:0] a);
        int unsigned w;
        logic [17:0] ppn;
        w   = a >> 2;
        ppn = 18'((w * 37 + 11) & 32'h3FFFF);
        return {((w % 5) != 0), 13'd0, ppn};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic seg_write(input int idx, input logic [31:0] base, input logic [16:0] bnd, input logic en);
        @(negedge clk);
        seg_wr_en = 1; seg_wr_idx = 3'(idx); seg_wr_base = base;
        seg_wr_bound = bnd; seg_wr_enable = en;
        @(negedge clk);
        seg_wr_en = 0;
        if (idx < 6) begin
            m_en[idx] = en; m_base[idx] = base; m_bnd[idx] = bnd;
        end
    endtask

    task automatic run(input logic [31:0] va, input int stall, input int lat, input int hold);
        int nreq, cyc, s;
        logic [31:0] addr, a_exp, w;
        logic [16:0] vpn;
        logic [1:0]  f_exp;
        logic [29:0] pa_exp, pa;
        s = int'(va[31:29]); vpn = va[28:12];
        a_exp = m_base[s] + {13'd0, vpn, 2'b00};
        w = pte_of(a_exp);
        pa_exp = 0;
        if (!m_en[s])           f_exp = 2'd3;
        else if (vpn > m_bnd[s]) f_exp = 2'd1;
        else if (!w[31])        f_exp = 2'd2;
        else begin f_exp = 2'd0; pa_exp = {w[17:0], va[11:0]}; end

        @(negedge clk);
        req_valid = 1; req_vaddr = va;
        @(negedge clk);
        req_valid = 0;
        nreq = 0; cyc = 1; addr = 0;
        chk(req_ready == 0, "R8 busy", req_ready, 0);
        while (!rsp_valid && cyc < 100) begin
            if (mem_req_valid) begin
                nreq++; addr = mem_req_addr;
                repeat (stall) begin @(negedge clk); cyc++; end
                mem_req_ready = 1;
                @(negedge clk); cyc++;
                mem_req_ready = 0;
                repeat (lat) begin @(negedge clk); cyc++; end
                mem_rsp_valid = 1; mem_rsp_data = pte_of(addr);
                @(negedge clk); cyc++;
                mem_rsp_valid = 0;
            end else begin
                @(negedge clk); cyc++;
            end
        end
        pa = rsp_paddr;
        chk(rsp_fault == f_exp, "R3/R4/R6/R7 fault code", rsp_fault, f_exp);
        chk(pa == pa_exp, "R1/R7 physical address", pa, pa_exp);
        chk(nreq == (f_exp == 2'd3 || f_exp == 2'd1 ? 0 : 1), "R5 read count", nreq, 0);
        if (nreq == 1) chk(addr == a_exp, "R5 entry address", addr, a_exp);
        chk(cyc == (nreq == 0 ? 2 : stall + lat + 3), "R12 latency", cyc, 0);
        repeat (hold) @(negedge clk);
        if (hold > 0) chk(rsp_valid && rsp_paddr == pa, "R10 hold", rsp_paddr, pa);
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        chk(req_ready == 1 && rsp_valid == 0, "R8 idle after take", req_ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_en[i] = 0; m_base[i] = 0; m_bnd[i] = 0; end
        rst = 1;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready == 1, "R11 ready", req_ready, 1);
        chk(rsp_valid == 0, "R11 rsp", rsp_valid, 0);
        chk(mem_req_valid == 0, "R11 mem", mem_req_valid, 0);
        run(32'h0000_1234, 0, 0, 0);      // R11 segments start disabled
        seg_write(6, 32'h0800_0000, 17'd9, 1'b1); // R2 unused index
        run(32'hC000_2001, 0, 0, 0);
        for (int i = 0; i < 6; i++)
            seg_write(i, 32'h0100_0000 + 32'(i) * 32'h0004_0000, 17'(i * 3 + 2), 1'b1);
        for (int s = 0; s < 8; s++) begin
            int lim = (s < 6) ? int'(m_bnd[s]) + 1 : 1;
            for (int v = 0; v <= lim; v++) begin
                logic [11:0] off = 12'((v * 293 + s * 17) & 12'hFFF);
                run({3'(s), 17'(v), off}, v % 3, (v + s) % 4, v % 2);
            end
        end
        seg_write(2, 32'h0100_8000, 17'd4, 1'b0); // R3 disabled segment
        run({3'd2, 17'd0, 12'h0AB}, 0, 0, 0);
        seg_write(5, 32'h0200_0000, 17'h1FFFF, 1'b1); // R4 full-size table
        run({3'd5, 17'h1FFFF, 12'hFFF}, 2, 3, 1);
        run({3'd5, 17'h10000, 12'h000}, 1, 0, 0);
        run({3'd5, 17'h00007, 12'h555}, 0, 5, 2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule